// File: doc/BRIEF.md
# CAN Controller Status Tracker

This block keeps the eight-bit, read-only status word of a CAN controller and drives it from two sources. The protocol engine sends single-cycle event strobes: a transmission starts, succeeds or fails, and a reception starts, stores its first byte, or ends valid or in error. The CPU sends single-cycle command strobes: request a transmission, abort it, release the front receive buffer, or clear the overrun flag. The block also watches the two error counters and a bus-off level from the fault logic. The bit-level protocol, framing, arbitration and the message RAM sit outside the block.

The block owns one transmit buffer and two receive slots. The transmit buffer is locked from the moment a request is accepted until the message leaves or is abandoned. While it is locked, CPU writes to the buffer RAM are blocked at the `tx_buf_we_o` gate. The receive slots form a two-deep queue. A valid message goes into the lowest free slot, and a release moves the second slot forward. A message that arrives with both slots full is dropped and raises the overrun flag.

All pins are plain strobes or levels, because no data passes through the block. There is no valid/ready handshake and no back-pressure. A command that the current state cannot accept is discarded. Every status bit is registered and changes on the clock edge that samples its cause.

Top module: `can_status_tracker`

## Requirements
- R1: Status bit positions are fixed for the decoder that reads them: 7 bus-off, 6 error warning, 5 transmitting, 4 receiving, 3 transmission complete, 2 transmit buffer released, 1 data overrun, 0 receive message available. After reset the word reads 8'h0C and `rx_full_o` reads 0.
- R2: Bit 7 equals the `bus_off_i` level sampled on the previous clock edge.
- R3: Bit 6 is 1 one cycle after either error counter is greater than or equal to WARN_LIMIT (default 96), and 0 one cycle after both counters are below it.
- R4: A transmit request while bit 2 is 1 clears bits 2 and 3 on the next edge. A request while bit 2 is 0 has no effect.
- R5: A start event while a message waits sets bit 5 on the next edge. Bit 5 clears on the edge after a success or failure event.
- R6: A success event during transmission sets bits 3 and 2 on the next edge. A failure event without a pending abort returns the message to waiting, with bit 2 still 0.
- R7: An abort while a message waits sets bit 2 and leaves bit 3 at 0. An abort during transmission is remembered: a later failure then sets bit 2 with bit 3 at 0, and a later success behaves as in R6.
- R8: `tx_buf_we_o` equals `cpu_tx_wr_i` while bit 2 is 1 and is 0 while bit 2 is 0.
- R9: Bit 4 is 1 from the edge after a start-of-reception event until the edge after a valid or error end event.
- R10: A valid end event stores the message in the lowest free slot (`rx_full_o[0]` is the front, `rx_full_o[1]` the second). Bit 0 is 1 whenever the front slot is full.
- R11: A release empties the front slot and moves the second slot forward, so bit 0 stays 1 if the second slot held a message.
- R12: A first-byte event that finds both slots full sets bit 1 and drops that message, so its end event stores nothing. Bit 1 stays 1 until a clear-overrun command.
- R13: A release in the same cycle as a first-byte or valid-end event takes effect first, so the freed slot can take the arriving message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req_i | input | 1 | CPU command: request transmission |
| tx_abort_i | input | 1 | CPU command: abort transmission |
| rx_release_i | input | 1 | CPU command: release front receive slot |
| clr_overrun_i | input | 1 | CPU command: clear overrun flag |
| cpu_tx_wr_i | input | 1 | CPU write attempt to transmit buffer RAM |
| tx_start_i | input | 1 | Engine: transmission begins |
| tx_ok_i | input | 1 | Engine: transmission succeeded |
| tx_fail_i | input | 1 | Engine: transmission ended unsuccessfully |
| rx_sof_i | input | 1 | Engine: reception begins |
| rx_byte0_i | input | 1 | Engine: first byte ready to store |
| rx_eof_ok_i | input | 1 | Engine: reception ended valid |
| rx_eof_err_i | input | 1 | Engine: reception ended in error |
| tx_err_cnt_i | input | CNT_W | Transmit error counter |
| rx_err_cnt_i | input | CNT_W | Receive error counter |
| bus_off_i | input | 1 | Bus-off level from fault logic |
| status_o | output | 8 | Status word |
| rx_full_o | output | RX_SLOTS | Receive slot occupancy, bit 0 front |
| tx_buf_we_o | output | 1 | Gated transmit buffer write enable |

## Verification
The collision of interest is a CPU release and an engine arrival in the same cycle. The bench fills both slots and then raises `rx_release_i` together with `rx_byte0_i` on one edge. It expects the overrun flag to stay clear and a following valid end to fill the slot again. It also pairs a release with a valid end while one slot is full, and expects exactly one occupied slot afterwards. A second collision is a transmit request that arrives while the buffer is locked. The bench judges this by the complete and transmitting bits and by the gated write enable, which must stay unchanged.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

  typedef struct packed {
    logic bus_off;
    logic err_warn;
    logic tx_busy;
    logic rx_busy;
    logic tx_done;
    logic tx_free;
    logic rx_ovr;
    logic rx_avail;
  } stat_word_t;

  typedef enum logic [1:0] {
    TX_FREE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

endpackage

// File: rtl/can_err_monitor.sv
module can_err_monitor #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             bus_off_i,
  output logic             warn_o,
  output logic             off_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WARN_LIMIT);

  logic warn_d;

  always_comb warn_d = (tx_cnt_i >= LIMIT) || (rx_cnt_i >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_o <= 1'b0;
      off_o  <= 1'b0;
    end else begin
      warn_o <= warn_d;
      off_o  <= bus_off_i;
    end
  end
endmodule

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl
  import can_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic abort_i,
  input  logic start_i,
  input  logic ok_i,
  input  logic fail_i,
  output logic free_o,
  output logic busy_o,
  output logic done_o
);
  tx_state_e state_q, state_d;
  logic      done_q, done_d;
  logic      abort_q, abort_d;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    abort_d = abort_q;
    unique case (state_q)
      TX_FREE: begin
        if (req_i) begin
          state_d = TX_WAIT;
          done_d  = 1'b0;
          abort_d = 1'b0;
        end
      end
      TX_WAIT: begin
        if (abort_i) begin
          state_d = TX_FREE;
        end else if (start_i) begin
          state_d = TX_SEND;
        end
      end
      TX_SEND: begin
        if (abort_i) abort_d = 1'b1;
        if (ok_i) begin
          state_d = TX_FREE;
          done_d  = 1'b1;
          abort_d = 1'b0;
        end else if (fail_i) begin
          state_d = (abort_q || abort_i) ? TX_FREE : TX_WAIT;
          abort_d = 1'b0;
        end
      end
      default: state_d = TX_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_FREE;
      done_q  <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  assign free_o = (state_q == TX_FREE);
  assign busy_o = (state_q == TX_SEND);
  assign done_o = done_q;
endmodule

// File: rtl/can_rx_queue.sv
module can_rx_queue #(
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             byte0_i,
  input  logic             eof_ok_i,
  input  logic             eof_err_i,
  input  logic             release_i,
  input  logic             clr_ovr_i,
  output logic [SLOTS-1:0] full_o,
  output logic             busy_o,
  output logic             ovr_o
);
  logic [SLOTS-1:0] full_q, full_d, after_rel, ins;
  logic             busy_q, busy_d;
  logic             ovr_q, ovr_d;
  logic             drop_q, drop_d;
  logic             no_room, ovr_set, store, found;

  always_comb begin
    after_rel = release_i ? (full_q >> 1) : full_q;
    no_room   = &after_rel;
    ins       = '0;
    found     = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!after_rel[i] && !found) begin
        ins[i] = 1'b1;
        found  = 1'b1;
      end
    end
    ovr_set = (byte0_i && no_room) ||
              (eof_ok_i && no_room && !drop_q && !byte0_i);
    store   = eof_ok_i && !drop_q && !(byte0_i && no_room) && !no_room;
    full_d  = after_rel | (store ? ins : '0);
    ovr_d   = ovr_set || (ovr_q && !clr_ovr_i);

    busy_d = busy_q;
    drop_d = drop_q;
    if (sof_i) begin
      busy_d = 1'b1;
      drop_d = 1'b0;
    end
    if (byte0_i && no_room) drop_d = 1'b1;
    if (eof_ok_i || eof_err_i) begin
      busy_d = 1'b0;
      drop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      full_q <= full_d;
      busy_q <= busy_d;
      ovr_q  <= ovr_d;
      drop_q <= drop_d;
    end
  end

  assign full_o = full_q;
  assign busy_o = busy_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/can_status_tracker.sv
module can_status_tracker
  import can_stat_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int RX_SLOTS   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_req_i,
  input  logic                tx_abort_i,
  input  logic                rx_release_i,
  input  logic                clr_overrun_i,
  input  logic                cpu_tx_wr_i,
  input  logic                tx_start_i,
  input  logic                tx_ok_i,
  input  logic                tx_fail_i,
  input  logic                rx_sof_i,
  input  logic                rx_byte0_i,
  input  logic                rx_eof_ok_i,
  input  logic                rx_eof_err_i,
  input  logic [CNT_W-1:0]    tx_err_cnt_i,
  input  logic [CNT_W-1:0]    rx_err_cnt_i,
  input  logic                bus_off_i,
  output logic [7:0]          status_o,
  output logic [RX_SLOTS-1:0] rx_full_o,
  output logic                tx_buf_we_o
);
  stat_word_t word;
  logic warn, off, tx_free, tx_busy, tx_done, rx_busy, rx_ovr;

  can_err_monitor #(.CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT)) u_err (
    .clk(clk), .rst_n(rst_n),
    .tx_cnt_i(tx_err_cnt_i), .rx_cnt_i(rx_err_cnt_i), .bus_off_i(bus_off_i),
    .warn_o(warn), .off_o(off)
  );

  can_tx_ctrl u_tx (
    .clk(clk), .rst_n(rst_n),
    .req_i(tx_req_i), .abort_i(tx_abort_i), .start_i(tx_start_i),
    .ok_i(tx_ok_i), .fail_i(tx_fail_i),
    .free_o(tx_free), .busy_o(tx_busy), .done_o(tx_done)
  );

  can_rx_queue #(.SLOTS(RX_SLOTS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sof_i(rx_sof_i), .byte0_i(rx_byte0_i), .eof_ok_i(rx_eof_ok_i),
    .eof_err_i(rx_eof_err_i), .release_i(rx_release_i), .clr_ovr_i(clr_overrun_i),
    .full_o(rx_full_o), .busy_o(rx_busy), .ovr_o(rx_ovr)
  );

  always_comb begin
    word.bus_off  = off;
    word.err_warn = warn;
    word.tx_busy  = tx_busy;
    word.rx_busy  = rx_busy;
    word.tx_done  = tx_done;
    word.tx_free  = tx_free;
    word.rx_ovr   = rx_ovr;
    word.rx_avail = rx_full_o[0];
  end

  assign status_o    = word;
  assign tx_buf_we_o = cpu_tx_wr_i && tx_free;
endmodule

// File: rtl/can_status_chk.sv
module can_status_chk #(
  parameter int RX_SLOTS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tx_req_i,
  input logic                tx_abort_i,
  input logic                tx_ok_i,
  input logic                rx_release_i,
  input logic                rx_eof_ok_i,
  input logic                clr_overrun_i,
  input logic                bus_off_i,
  input logic [7:0]          status_o,
  input logic [RX_SLOTS-1:0] rx_full_o,
  input logic                tx_buf_we_o
);
  // R2
  a_r2_bus_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_o[7] == $past(bus_off_i));
  // R4
  a_r4_req_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_i && status_o[2]) |=> (!status_o[2] && !status_o[3]));
  // R5
  a_r5_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5] |-> !status_o[2]);
  // R6
  a_r6_ok_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && tx_ok_i) |=> (status_o[3] && status_o[2]));
  // R8
  a_r8_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tx_buf_we_o |-> status_o[2]);
  // R10
  a_r10_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_o[1] |-> rx_full_o[0]);
  // R11
  a_r11_shift_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_release_i && rx_full_o[1]) |=> status_o[0]);
  // R12
  a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] && !clr_overrun_i) |=> status_o[1]);
endmodule

bind can_status_tracker can_status_chk #(.RX_SLOTS(RX_SLOTS)) u_chk (.*);

// File: tb/tb_can_status_tracker.sv
module tb_can_status_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req_i = 0, tx_abort_i = 0, rx_release_i = 0, clr_overrun_i = 0;
  logic cpu_tx_wr_i = 0, tx_start_i = 0, tx_ok_i = 0, tx_fail_i = 0;
  logic rx_sof_i = 0, rx_byte0_i = 0, rx_eof_ok_i = 0, rx_eof_err_i = 0;
  logic [7:0] tx_err_cnt_i = 0, rx_err_cnt_i = 0;
  logic bus_off_i = 0;
  logic [7:0] status_o;
  logic [1:0] rx_full_o;
  logic tx_buf_we_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_status_tracker dut (.*);

  // event mask bits
  localparam int E_REQ = 0, E_ABT = 1, E_REL = 2, E_CLR = 3, E_STA = 4,
                 E_OK = 5, E_FAIL = 6, E_SOF = 7, E_B0 = 8, E_EOK = 9, E_EERR = 10;

  task automatic ev(input logic [10:0] m);
    tx_req_i = m[E_REQ]; tx_abort_i = m[E_ABT]; rx_release_i = m[E_REL];
    clr_overrun_i = m[E_CLR]; tx_start_i = m[E_STA]; tx_ok_i = m[E_OK];
    tx_fail_i = m[E_FAIL]; rx_sof_i = m[E_SOF]; rx_byte0_i = m[E_B0];
    rx_eof_ok_i = m[E_EOK]; rx_eof_err_i = m[E_EERR];
    @(negedge clk);
    {tx_req_i, tx_abort_i, rx_release_i, clr_overrun_i, tx_start_i, tx_ok_i,
     tx_fail_i, rx_sof_i, rx_byte0_i, rx_eof_ok_i, rx_eof_err_i} = '0;
  endtask

  function automatic logic [10:0] bit_of(input int b);
    return 11'(1) << b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic t_reset;
    chk_eq("R1 reset status", status_o, 8'h0C);
    chk_eq("R1 reset occupancy", rx_full_o, 0);
  endtask

  task automatic t_bus_err;
    bus_off_i = 1; @(negedge clk);
    chk_eq("R2 bus-off set", status_o[7], 1);
    bus_off_i = 0; @(negedge clk);
    chk_eq("R2 bus-on", status_o[7], 0);
    tx_err_cnt_i = 95; @(negedge clk);
    chk_eq("R3 tec 95", status_o[6], 0);
    tx_err_cnt_i = 96; @(negedge clk);
    chk_eq("R3 tec 96", status_o[6], 1);
    tx_err_cnt_i = 0; rx_err_cnt_i = 200; @(negedge clk);
    chk_eq("R3 rec 200", status_o[6], 1);
    rx_err_cnt_i = 0; @(negedge clk);
    chk_eq("R3 both low", status_o[6], 0);
  endtask

  task automatic t_tx_basic;
    cpu_tx_wr_i = 1; #1;
    chk_eq("R8 write passes when released", tx_buf_we_o, 1);
    cpu_tx_wr_i = 0;
    ev(bit_of(E_REQ));
    chk_eq("R4 req locks", status_o[3:2], 2'b00);
    cpu_tx_wr_i = 1; #1;
    chk_eq("R8 write blocked when locked", tx_buf_we_o, 0);
    cpu_tx_wr_i = 0;
    ev(bit_of(E_REQ));
    chk_eq("R4 req while locked ignored", status_o[5:2], 4'b0000);
    ev(bit_of(E_STA));
    chk_eq("R5 transmitting", status_o[5:2], 4'b1000);
    ev(bit_of(E_OK));
    chk_eq("R6 success frees", status_o[5:2], 4'b0011);
  endtask

  task automatic t_tx_fail_abort;
    ev(bit_of(E_REQ)); ev(bit_of(E_STA));
    ev(bit_of(E_FAIL));
    chk_eq("R6 fail back to waiting", status_o[5:2], 4'b0000);
    ev(bit_of(E_STA));
    ev(bit_of(E_ABT));
    chk_eq("R7 abort during send keeps lock", status_o[5:2], 4'b1000);
    ev(bit_of(E_FAIL));
    chk_eq("R7 aborted fail frees incomplete", status_o[5:2], 4'b0001);
    ev(bit_of(E_REQ)); ev(bit_of(E_ABT));
    chk_eq("R7 abort while waiting", status_o[5:2], 4'b0001);
    ev(bit_of(E_REQ)); ev(bit_of(E_STA)); ev(bit_of(E_ABT));
    ev(bit_of(E_OK));
    chk_eq("R7 aborted but succeeded", status_o[5:2], 4'b0011);
  endtask

  task automatic t_rx_fill;
    ev(bit_of(E_SOF));
    chk_eq("R9 receiving", status_o[4], 1);
    ev(bit_of(E_B0)); ev(bit_of(E_EOK));
    chk_eq("R9 idle after end", status_o[4], 0);
    chk_eq("R10 first stored", {rx_full_o, status_o[0]}, 3'b011);
    ev(bit_of(E_SOF)); ev(bit_of(E_EERR));
    chk_eq("R9 error end idle and nothing stored", {status_o[4], rx_full_o}, 3'b001);
    ev(bit_of(E_SOF)); ev(bit_of(E_B0)); ev(bit_of(E_EOK));
    chk_eq("R10 second stored", rx_full_o, 2'b11);
    ev(bit_of(E_REL));
    chk_eq("R11 shift forward", {rx_full_o, status_o[0]}, 3'b011);
    ev(bit_of(E_REL));
    chk_eq("R11 empty after two releases", {rx_full_o, status_o[0]}, 3'b000);
  endtask

  task automatic t_overrun;
    ev(bit_of(E_SOF)); ev(bit_of(E_EOK));
    ev(bit_of(E_SOF)); ev(bit_of(E_EOK));
    ev(bit_of(E_SOF)); ev(bit_of(E_B0));
    chk_eq("R12 overrun set", status_o[1], 1);
    ev(bit_of(E_EOK));
    chk_eq("R12 dropped message", rx_full_o, 2'b11);
    ev(bit_of(E_REL)); ev(bit_of(E_REL));
    chk_eq("R12 only two held", {rx_full_o, status_o[1]}, 3'b001);
    ev(bit_of(E_CLR));
    chk_eq("R12 cleared", status_o[1], 0);
  endtask

  task automatic t_race;
    ev(bit_of(E_SOF)); ev(bit_of(E_EOK));
    ev(bit_of(E_SOF)); ev(bit_of(E_EOK));
    ev(bit_of(E_SOF));
    ev(bit_of(E_REL) | bit_of(E_B0));
    chk_eq("R13 release before byte0", {rx_full_o, status_o[1]}, 3'b010);
    ev(bit_of(E_EOK));
    chk_eq("R13 arrival fills freed slot", rx_full_o, 2'b11);
    ev(bit_of(E_REL));
    ev(bit_of(E_SOF));
    ev(bit_of(E_REL) | bit_of(E_EOK));
    chk_eq("R13 release with end", rx_full_o, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bus_err();
    t_tx_basic();
    t_tx_fail_abort();
    t_rx_fill();
    t_overrun();
    t_race();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule